// File: doc/BRIEF.md
# Skewed Vote Branch Direction Predictor

The block predicts the direction of conditional branches from four banks of 2-bit saturating counters. One bank is addressed by the branch address alone. Two more are addressed by two different hashes of the address and the global branch history. A chooser bank, addressed by a third hash, decides whether the final answer is the address-only prediction or a three-way majority vote of the address-only bank and the two history banks.

A front end drives a branch address on the predict port and reads the direction back in the same cycle. It also reads the current history value, keeps it with the branch, and returns that snapshot with the resolved outcome on the update port. A selective training policy runs on update. It leaves the banks untouched when all three components agreed and were right. It trains only the components that were right when that is enough, and trains all of them when the chooser cannot fix the miss. The block holds its own global history register and shifts each resolved outcome into it.

Top module: `skew_vote_predictor`

## Requirements
- R1: After reset every counter holds 1, the history register holds 0, and every address predicts not-taken (pred_taken = 0).
- R2: With a = pc[PC_SHIFT +: IDX_W], fs = history bits [HIST_W/2-1:0] XOR-folded into IDX_W bits (bit i goes to position i mod IDX_W), and ff = all HIST_W history bits folded the same way: address bank index = a; first history bank index = a ^ fs; second history bank index = bit-reverse(a) ^ ff; chooser index = a ^ ff.
- R3: A counter predicts taken when its value is 2 or 3. The vote is the majority of the three component predictions. A chooser value of 2 or 3 selects the vote, and otherwise the address bank prediction is selected.
- R4: Counters move by at most one step per update and saturate at 0 and 3.
- R5: If the selected prediction was correct and all three components agreed, no counter changes.
- R6: If the selected prediction was correct and the components disagreed, each component that matched the outcome steps toward it. The chooser steps toward the vote when the vote matched and the address bank did not, and the other way round. It is left alone when the vote and the address bank agree.
- R7: On a misprediction the chooser is stepped first by the rule of R6. The selection is then redone with the new chooser value. If that is now correct, only the matching components step toward the outcome.
- R8: If the redone selection is still wrong, all three components step toward the outcome.
- R9: On each update the history register shifts left and takes the outcome into bit 0. It is shown on pred_hist. The update indexes the banks with the supplied snapshot, not with the live register.
- R10: The prediction is combinational from the predict address. An update takes effect at the clock edge that ends its cycle, so a prediction made in the same cycle still sees the older state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | ADDR_W | Address of the branch to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | Current global history, kept for the update |
| upd_valid | input | 1 | Update strobe |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_hist | input | HIST_W | History snapshot taken at prediction |
| upd_taken | input | 1 | Resolved direction |

## Verification
The bench builds the block with IDX_W = 4 and HIST_W = 10, so each bank has only 16 entries. Two dozen random branch addresses then alias heavily in every bank. The 10-bit history folds over itself into 4 index bits, which exercises the wrap-around of the fold. Together these drive all four training cases (quiet agreement, partial strengthening, chooser repair and full retraining) and counter saturation within a few thousand branches. Occasional stale history snapshots show that updates use the supplied history rather than the live register.

// File: rtl/bp_pkg.sv
package bp_pkg;

   typedef logic [1:0] ctr_t;

   localparam ctr_t CTR_INIT = 2'd1;
   localparam int   NBANK    = 4;
   localparam int   BK_BIM   = 0;
   localparam int   BK_G0    = 1;
   localparam int   BK_G1    = 2;
   localparam int   BK_META  = 3;

   function automatic ctr_t ctr_step(ctr_t c, logic up);
      if (up) return (c == 2'd3) ? c : c + 2'd1;
      else    return (c == 2'd0) ? c : c - 2'd1;
   endfunction

   function automatic logic maj3(logic a, logic b, logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

   function automatic logic select_dir(ctr_t cb, ctr_t c0, ctr_t c1, ctr_t cm);
      return cm[1] ? maj3(cb[1], c0[1], c1[1]) : cb[1];
   endfunction

endpackage

// File: rtl/bp_index_hash.sv
module bp_index_hash
   import bp_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int IDX_W         = 6,
   parameter int HIST_W        = 10,
   parameter int PC_SHIFT      = 2,
   parameter bit G1_PC_REVERSE = 1'b1
) (
   input  logic [ADDR_W-1:0]                pc,
   input  logic [HIST_W-1:0]                hist,
   output logic [NBANK-1:0][IDX_W-1:0]      idx
);
   localparam int SHORT_LEN = (HIST_W / 2 < 1) ? 1 : HIST_W / 2;

   logic [IDX_W-1:0] pc_idx;
   logic [IDX_W-1:0] pc_alt;
   logic [IDX_W-1:0] fold_short;
   logic [IDX_W-1:0] fold_full;

   assign pc_idx = pc[PC_SHIFT +: IDX_W];

   always_comb begin
      fold_short = '0;
      fold_full  = '0;
      for (int i = 0; i < HIST_W; i++) begin
         fold_full[i % IDX_W] = fold_full[i % IDX_W] ^ hist[i];
         if (i < SHORT_LEN)
            fold_short[i % IDX_W] = fold_short[i % IDX_W] ^ hist[i];
      end
   end

   generate
      if (G1_PC_REVERSE) begin : g_rev
         always_comb begin
            for (int j = 0; j < IDX_W; j++) pc_alt[j] = pc_idx[IDX_W-1-j];
         end
      end else begin : g_rot
         if (IDX_W > 1) begin : g_rot_n
            assign pc_alt = {pc_idx[0], pc_idx[IDX_W-1:1]};
         end else begin : g_rot_1
            assign pc_alt = pc_idx;
         end
      end
   endgenerate

   assign idx[BK_BIM]  = pc_idx;
   assign idx[BK_G0]   = pc_idx ^ fold_short;
   assign idx[BK_G1]   = pc_alt ^ fold_full;
   assign idx[BK_META] = pc_idx ^ fold_full;

endmodule

// File: rtl/bp_ctr_bank.sv
module bp_ctr_bank
   import bp_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_a_idx,
   output ctr_t             rd_a,
   input  logic [IDX_W-1:0] rd_b_idx,
   output ctr_t             rd_b,
   input  logic             we,
   input  logic [IDX_W-1:0] wr_idx,
   input  ctr_t             wr_val
);
   localparam int ENTRIES = 1 << IDX_W;

   ctr_t mem [ENTRIES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) mem[i] <= CTR_INIT;
      end else if (we) begin
         mem[wr_idx] <= wr_val;
      end
   end

   assign rd_a = mem[rd_a_idx];
   assign rd_b = mem[rd_b_idx];

   AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> ((int'(wr_val) - int'(mem[wr_idx]) <= 1) &&
              (int'(mem[wr_idx]) - int'(wr_val) <= 1)))
      else $error("counter jumped more than one step"); // R4

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (mem[$past(wr_idx)] == $past(wr_val)))
      else $error("counter write lost"); // R4

endmodule

// File: rtl/bp_update_policy.sv
module bp_update_policy
   import bp_pkg::*;
(
   input  ctr_t [NBANK-1:0] cur,
   input  logic             taken,
   output logic [NBANK-1:0] we,
   output ctr_t [NBANK-1:0] nxt,
   output logic             first_ok,
   output logic             agree,
   output logic             second_ok
);
   logic pb, p0, p1, vote, meta_move;
   ctr_t meta_new;

   always_comb begin
      pb        = cur[BK_BIM][1];
      p0        = cur[BK_G0][1];
      p1        = cur[BK_G1][1];
      vote      = maj3(pb, p0, p1);
      first_ok  = ((cur[BK_META][1] ? vote : pb) == taken);
      agree     = (pb == p0) && (p0 == p1);
      meta_move = (vote != pb);
      meta_new  = meta_move ? ctr_step(cur[BK_META], vote == taken) : cur[BK_META];
      second_ok = ((meta_new[1] ? vote : pb) == taken);
   end

   generate
      for (genvar c = 0; c < NBANK - 1; c++) begin : g_comp
         logic hit;
         assign hit    = (cur[c][1] == taken);
         assign we[c]  = first_ok ? (!agree && hit) : (second_ok ? hit : 1'b1);
         assign nxt[c] = ctr_step(cur[c], taken);
      end
   endgenerate

   assign we[BK_META]  = meta_move;
   assign nxt[BK_META] = meta_new;

endmodule

// File: rtl/skew_vote_predictor.sv
module skew_vote_predictor
   import bp_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int IDX_W         = 6,
   parameter int HIST_W        = 10,
   parameter int PC_SHIFT      = 2,
   parameter bit G1_PC_REVERSE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] pred_pc,
   output logic              pred_taken,
   output logic [HIST_W-1:0] pred_hist,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_pc,
   input  logic [HIST_W-1:0] upd_hist,
   input  logic              upd_taken
);
   generate
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
         $error("IDX_W must lie in 1..12");
      end
      if (HIST_W < 2) begin : g_bad_hist
         $error("HIST_W must be at least 2");
      end
      if (PC_SHIFT + IDX_W > ADDR_W) begin : g_bad_pc
         $error("address too narrow for the index field");
      end
   endgenerate

   logic [NBANK-1:0][IDX_W-1:0] p_idx, u_idx;
   ctr_t [NBANK-1:0]            p_rd, u_rd, nxt;
   logic [NBANK-1:0]            pol_we, wr_en;
   logic                        pol_first_ok, pol_agree, pol_second_ok;
   logic [HIST_W-1:0]           ghr;

   bp_index_hash #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_W(HIST_W),
      .PC_SHIFT(PC_SHIFT), .G1_PC_REVERSE(G1_PC_REVERSE)
   ) u_hash_pred (.pc(pred_pc), .hist(ghr), .idx(p_idx));

   bp_index_hash #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_W(HIST_W),
      .PC_SHIFT(PC_SHIFT), .G1_PC_REVERSE(G1_PC_REVERSE)
   ) u_hash_upd (.pc(upd_pc), .hist(upd_hist), .idx(u_idx));

   bp_update_policy u_policy (
      .cur(u_rd), .taken(upd_taken), .we(pol_we), .nxt(nxt),
      .first_ok(pol_first_ok), .agree(pol_agree), .second_ok(pol_second_ok)
   );

   assign wr_en = upd_valid ? pol_we : '0;

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         bp_ctr_bank #(.IDX_W(IDX_W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .rd_a_idx(p_idx[b]), .rd_a(p_rd[b]),
            .rd_b_idx(u_idx[b]), .rd_b(u_rd[b]),
            .we(wr_en[b]), .wr_idx(u_idx[b]), .wr_val(nxt[b])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)         ghr <= '0;
      else if (upd_valid) ghr <= {ghr[HIST_W-2:0], upd_taken};
   end

   assign pred_hist  = ghr;
   assign pred_taken = select_dir(p_rd[BK_BIM], p_rd[BK_G0], p_rd[BK_G1], p_rd[BK_META]);

   logic u_vote;
   assign u_vote = maj3(u_rd[BK_BIM][1], u_rd[BK_G0][1], u_rd[BK_G1][1]);

   AST_GHR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> (ghr[0] == $past(upd_taken)) &&
                    (ghr[HIST_W-1:1] == $past(ghr[HIST_W-2:0])))
      else $error("history did not shift"); // R9

   AST_GHR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_valid |=> $stable(ghr))
      else $error("history moved without update"); // R9

   AST_AGREE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && pol_first_ok && pol_agree) |-> (wr_en == '0))
      else $error("write on agreed correct prediction"); // R5

   AST_MISS_CHOOSER: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !pol_first_ok && (u_vote != u_rd[BK_BIM][1])) |-> wr_en[BK_META])
      else $error("chooser not trained on miss"); // R7

   AST_STILL_WRONG: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !pol_first_ok && !pol_second_ok) |-> (&wr_en[BK_G1:BK_BIM]))
      else $error("components not all retrained"); // R8

endmodule

// File: tb/sim_skew_vote_predictor.sv
module sim_skew_vote_predictor;
   localparam int AW = 32;
   localparam int IW = 4;
   localparam int HW = 10;
   localparam int SH = 2;
   localparam int NE = 1 << IW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] pred_pc = '0;
   logic          pred_taken;
   logic [HW-1:0] pred_hist;
   logic          upd_valid = 1'b0;
   logic [AW-1:0] upd_pc = '0;
   logic [HW-1:0] upd_hist = '0;
   logic          upd_taken = 1'b0;

   always #10 clk = ~clk;

   skew_vote_predictor #(.ADDR_W(AW), .IDX_W(IW), .HIST_W(HW), .PC_SHIFT(SH)) u0 (
      .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
      .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
      .upd_hist(upd_hist), .upd_taken(upd_taken)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int m_bim [NE];
   int m_g0  [NE];
   int m_g1  [NE];
   int m_met [NE];
   int m_ghr = 0;
   string last_tag = "R3 initial";

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int fold(int h, int len);
      int r = 0;
      for (int i = 0; i < len; i++)
         if ((h >> i) & 1) r = r ^ (1 << (i % IW));
      return r;
   endfunction

   function automatic int ix_b(int pc);
      return (pc >> SH) % NE;
   endfunction
   function automatic int ix_0(int pc, int h);
      return ix_b(pc) ^ fold(h, HW / 2);
   endfunction
   function automatic int ix_1(int pc, int h);
      int a = ix_b(pc);
      int r = 0;
      for (int j = 0; j < IW; j++) if ((a >> j) & 1) r = r | (1 << (IW - 1 - j));
      return r ^ fold(h, HW);
   endfunction
   function automatic int ix_m(int pc, int h);
      return ix_b(pc) ^ fold(h, HW);
   endfunction

   function automatic int towards(int c, int t);
      if (t != 0) return (c < 3) ? c + 1 : 3;
      return (c > 0) ? c - 1 : 0;
   endfunction

   function automatic int mpred(int pc, int h);
      int b = (m_bim[ix_b(pc)] >= 2);
      int x = (m_g0[ix_0(pc, h)] >= 2);
      int y = (m_g1[ix_1(pc, h)] >= 2);
      int v = (b + x + y >= 2);
      return (m_met[ix_m(pc, h)] >= 2) ? v : b;
   endfunction

   function automatic string mupdate(int pc, int h, int t);
      int ib = ix_b(pc), i0 = ix_0(pc, h), i1 = ix_1(pc, h), im = ix_m(pc, h);
      int b = (m_bim[ib] >= 2), x = (m_g0[i0] >= 2), y = (m_g1[i1] >= 2);
      int v = (b + x + y >= 2);
      int first = (m_met[im] >= 2) ? v : b;
      int nm;
      bit all_comp;
      string tag;
      if (first == t && b == x && x == y) return "R5 quiet";
      nm = m_met[im];
      if (v != b) nm = (v == t) ? towards(nm, 1) : towards(nm, 0);
      if (first == t) begin
         tag = "R6 partial";
         all_comp = 0;
      end else if (((nm >= 2) ? v : b) == t) begin
         tag = "R7 repaired";
         all_comp = 0;
      end else begin
         tag = "R8 retrain";
         all_comp = 1;
      end
      m_met[im] = nm;
      if (all_comp || b == t) m_bim[ib] = towards(m_bim[ib], t);
      if (all_comp || x == t) m_g0[i0]  = towards(m_g0[i0], t);
      if (all_comp || y == t) m_g1[i1]  = towards(m_g1[i1], t);
      return tag;
   endfunction

   task automatic branch(int pc, int t, bit stale, string force_tag);
      int exp_p, h;
      string ptag;
      @(negedge clk);
      pred_pc = pc;
      upd_valid = 1'b0;
      #1;
      exp_p = mpred(pc, m_ghr);
      ptag = (force_tag != "") ? force_tag : {"R3 after ", last_tag};
      chk(ptag, int'(pred_taken), exp_p);
      chk("R9 history", int'(pred_hist), m_ghr);
      h = stale ? int'($urandom % (1 << HW)) : m_ghr;
      upd_valid = 1'b1;
      upd_pc = pc;
      upd_hist = h[HW-1:0];
      upd_taken = t[0];
      #1;
      chk("R10 same-cycle prediction", int'(pred_taken), exp_p);
      @(posedge clk);
      last_tag = mupdate(pc, h, t);
      if (stale) last_tag = {"R2 stale snapshot, ", last_tag};
      m_ghr = ((m_ghr << 1) | t) & ((1 << HW) - 1);
      #1;
      upd_valid = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < NE; i++) begin
         m_bim[i] = 1; m_g0[i] = 1; m_g1[i] = 1; m_met[i] = 1;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         pred_pc = 32'h400 + k * 52;
         #1;
         chk("R1 reset prediction", int'(pred_taken), 0);
         chk("R1 reset history", int'(pred_hist), 0);
      end
      for (int k = 0; k < 8; k++) branch(32'h40, 1, 0, "R4 saturating train");
      branch(32'h40, 0, 0, "R4 saturated");
      branch(32'h40, 0, 0, "R4 one step down");
      branch(32'h40, 1, 0, "R4 after flip");
      for (int n = 0; n < 2500; n++) begin
         int k = int'($urandom % 24);
         int pc = 32'h1000 + k * 4 + (k / 8) * 32'h100;
         int t;
         case (k % 3)
            0: t = ($urandom % 16 != 0);
            1: t = (m_ghr >> 1) & 1;
            default: t = int'($urandom % 2);
         endcase
         branch(pc, t, (n % 37) == 5, "");
      end
      @(negedge clk);
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule